// File: doc/BRIEF.md
# Bus Clock Source Switch Sequencer

This block sits between the command-issue path of a two-channel parallel ATA host and the clock mux that feeds the channel timing logic. Each time a command is offered, it works out which clock the channel should run from. A write command, or a host bus running at 66 MHz, calls for the PLL clock. Any other command runs from the PCI clock. The choice is compared with the source currently selected.

A change is made only when two conditions hold: the selection differs from the current source, and the partner channel reports idle. The change is a fixed chain of one-clock steps:

1. Float the drivers of every channel.
2. Present the new source code.
3. Hold the channel reset and pulse each channel's state-machine reset.
4. Release the channel reset.
5. Reconnect the bus.

The command is acknowledged only when that chain has finished. When no change is needed, or the partner is busy, the command is acknowledged on the existing clock one cycle after it is seen.

Top module: `clksw_seq`

## Requirements
- R1: While reset is asserted and after it ends: bus isolation, channel reset, state-machine resets, acknowledge and done are all low, the source code output is 0x23 and the current-source flag is 0 (PCI clock).
- R2: The required source is the PLL clock when `issue_write` or `bus_66` is high, and the PCI clock otherwise.
- R3: If `partner_idle` is low when a request is taken, no switch is made. `issue_ack` rises in the cycle after the request is taken, with no isolation.
- R4: If the required source equals `cur_src_pll`, no switch is made. `issue_ack` rises in the cycle after the request is taken.
- R5: `clk_src_code` is 0x21 for the PLL clock and 0x23 for the PCI clock. It never shows any other value.
- R6: A switch runs six one-clock steps after the request is taken:
  - step 1: all `bus_iso` bits high;
  - step 2: `clk_src_code` changes to the new code;
  - steps 3 and 4: `chan_rst` high;
  - step 4: every `sm_rst` bit high for one cycle;
  - step 5: `chan_rst` low while isolation is still held;
  - step 6: isolation low, with `done` high for one cycle.
- R7: During a switch, `issue_ack` stays low until step 6, where it is high for one cycle. It is never high while any channel is isolated.
- R8: `cur_src_pll` keeps its old value for the whole sequence. It takes the new source in the cycle after step 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_req | input | 1 | Command offered; held until acknowledged |
| issue_write | input | 1 | Offered command is a write |
| partner_idle | input | 1 | Partner channel has no command in flight |
| bus_66 | input | 1 | Host bus runs at 66 MHz |
| issue_ack | output | 1 | Command may proceed (one-cycle pulse) |
| bus_iso | output | NCH | Per-channel bus float control |
| clk_src_code | output | 8 | Clock source select code |
| chan_rst | output | 1 | Channel reset level |
| sm_rst | output | NCH | Per-channel state-machine reset strobe |
| done | output | 1 | Switch sequence completed (one-cycle pulse) |
| cur_src_pll | output | 1 | Currently selected source is the PLL clock |

## Verification
The checker watches the step ordering on every cycle:
- the channel reset and the state-machine strobes appear only under full isolation;
- the source code changes only while the bus is floated;
- acknowledge never coincides with isolation;
- the current-source flag moves only right after a done pulse;
- a sequence starts only when the partner was idle and the requested source differed.

The exact step on which each output moves, and the actual source code reached, are shown only by the bench. Its directed and random command streams are compared against a bench-side model of the current source.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] SRC_CODE_PLL = 8'h21;
  localparam logic [CODE_W-1:0] SRC_CODE_PCI = 8'h23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_ISO,
    ST_SEL,
    ST_CRST,
    ST_SMR,
    ST_REL,
    ST_RECON
  } seq_state_e;
endpackage

// File: rtl/clksw_policy.sv
module clksw_policy (
  input  logic issue_write,
  input  logic bus_66,
  input  logic partner_idle,
  input  logic cur_pll,
  output logic need_pll,
  output logic do_switch
);
  always_comb begin
    need_pll  = issue_write | bus_66;
    do_switch = partner_idle & (need_pll != cur_pll);
  end
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       do_switch,
  output seq_state_e state
);
  seq_state_e state_d;
  seq_state_e state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req) state_d = do_switch ? ST_ISO : ST_ACK;
      ST_ACK:   state_d = ST_IDLE;
      ST_ISO:   state_d = ST_SEL;
      ST_SEL:   state_d = ST_CRST;
      ST_CRST:  state_d = ST_SMR;
      ST_SMR:   state_d = ST_REL;
      ST_REL:   state_d = ST_RECON;
      ST_RECON: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/clksw_outs.sv
module clksw_outs
  import clksw_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic              start,
  input  logic              need_pll,
  output logic [NCH-1:0]    bus_iso,
  output logic [CODE_W-1:0] clk_src_code,
  output logic              chan_rst,
  output logic [NCH-1:0]    sm_rst,
  output logic              issue_ack,
  output logic              done,
  output logic              cur_pll
);
  logic in_iso, in_smr;
  logic tgt_q, tgt_d, tgt_en;
  logic [CODE_W-1:0] code_q, code_d;
  logic code_en;
  logic cur_q, cur_d, cur_en;

  always_comb begin
    in_iso    = (state == ST_ISO) || (state == ST_SEL) || (state == ST_CRST) ||
                (state == ST_SMR) || (state == ST_REL);
    in_smr    = (state == ST_SMR);
    chan_rst  = (state == ST_CRST) || (state == ST_SMR);
    issue_ack = (state == ST_ACK) || (state == ST_RECON);
    done      = (state == ST_RECON);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign bus_iso[ch] = in_iso;
    assign sm_rst[ch]  = in_smr;
  end

  always_comb begin
    tgt_en  = start;
    tgt_d   = need_pll;
    code_en = (state == ST_ISO);
    code_d  = tgt_q ? SRC_CODE_PLL : SRC_CODE_PCI;
    cur_en  = (state == ST_RECON);
    cur_d   = tgt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= 1'b0;
      code_q <= SRC_CODE_PCI;
      cur_q  <= 1'b0;
    end else begin
      if (tgt_en)  tgt_q  <= tgt_d;
      if (code_en) code_q <= code_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

  assign clk_src_code = code_q;
  assign cur_pll      = cur_q;
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_req,
  input  logic              issue_write,
  input  logic              partner_idle,
  input  logic              bus_66,
  output logic              issue_ack,
  output logic [NCH-1:0]    bus_iso,
  output logic [CODE_W-1:0] clk_src_code,
  output logic              chan_rst,
  output logic [NCH-1:0]    sm_rst,
  output logic              done,
  output logic              cur_src_pll
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       need_pll, do_switch, start;
  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  clksw_policy u_policy (
    .issue_write (issue_write),
    .bus_66      (bus_66),
    .partner_idle(partner_idle),
    .cur_pll     (cur_src_pll),
    .need_pll    (need_pll),
    .do_switch   (do_switch)
  );

  clksw_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (issue_req),
    .do_switch(do_switch),
    .state    (state)
  );

  assign start = (state == ST_IDLE) && issue_req && do_switch;

  clksw_outs #(.NCH(NCH)) u_outs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .state       (state),
    .start       (start),
    .need_pll    (need_pll),
    .bus_iso     (bus_iso),
    .clk_src_code(clk_src_code),
    .chan_rst    (chan_rst),
    .sm_rst      (sm_rst),
    .issue_ack   (issue_ack),
    .done        (done),
    .cur_pll     (cur_src_pll)
  );
endmodule

// File: rtl/clksw_seq_chk.sv
module clksw_seq_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           issue_req,
  input logic           issue_write,
  input logic           partner_idle,
  input logic           bus_66,
  input logic           issue_ack,
  input logic [NCH-1:0] bus_iso,
  input logic [7:0]     clk_src_code,
  input logic           chan_rst,
  input logic [NCH-1:0] sm_rst,
  input logic           done,
  input logic           cur_src_pll
);
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_code == 8'h21) || (clk_src_code == 8'h23)); // R5
  AST_RST_UNDER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |-> (&bus_iso)); // R6
  AST_SMR_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (|sm_rst) |-> chan_rst); // R6
  AST_CODE_MOVES_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_src_code) |-> (&bus_iso)); // R6
  AST_ACK_NO_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ack |-> !(|bus_iso)); // R7
  AST_CUR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_src_pll) |-> $past(done)); // R8
  AST_START_PARTNER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_iso[0]) |-> $past(partner_idle)); // R3
  AST_START_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_iso[0]) |-> ($past(issue_write | bus_66) != cur_src_pll)); // R4
endmodule

bind clksw_seq clksw_seq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/clksw_seq_tb_top.sv
`timescale 1ns/1ps
module clksw_seq_tb_top;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_req = 1'b0, issue_write = 1'b0, partner_idle = 1'b1, bus_66 = 1'b0;
  logic issue_ack, chan_rst, done, cur_src_pll;
  logic [NCH-1:0] bus_iso, sm_rst;
  logic [7:0] clk_src_code;

  int n_chk = 0;
  int n_err = 0;
  bit model_pll = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clksw_seq #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_write(issue_write),
    .partner_idle(partner_idle), .bus_66(bus_66), .issue_ack(issue_ack),
    .bus_iso(bus_iso), .clk_src_code(clk_src_code), .chan_rst(chan_rst),
    .sm_rst(sm_rst), .done(done), .cur_src_pll(cur_src_pll)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit need_of(bit w, bit b);
    return w | b;
  endfunction

  function automatic logic [7:0] code_of(bit pll);
    return pll ? 8'h21 : 8'h23;
  endfunction

  task automatic check_quiet(string tag);
    chk({tag, " R1 iso"}, bus_iso, '0);
    chk({tag, " R1 chan_rst"}, chan_rst, 0);
    chk({tag, " R1 sm_rst"}, sm_rst, '0);
    chk({tag, " R1 ack"}, issue_ack, 0);
    chk({tag, " R1 done"}, done, 0);
  endtask

  task automatic run_cmd(bit w, bit pi, bit b);
    bit need, sw;
    logic [7:0] old_code, new_code;
    need = need_of(w, b);
    sw = pi && (need != model_pll);
    old_code = code_of(model_pll);
    new_code = code_of(need);
    @(negedge clk);
    issue_write = w; partner_idle = pi; bus_66 = b; issue_req = 1'b1;
    if (sw) begin
      for (int n = 1; n <= 6; n++) begin
        @(negedge clk);
        chk("R6 bus_iso step", bus_iso, {NCH{n <= 5}});
        chk("R2/R5 source code step", clk_src_code, (n >= 2) ? new_code : old_code);
        chk("R6 chan_rst step", chan_rst, (n == 3) || (n == 4));
        chk("R6 sm_rst step", sm_rst, {NCH{n == 4}});
        chk("R7 ack withheld", issue_ack, n == 6);
        chk("R6 done step", done, n == 6);
        chk("R8 cur held", cur_src_pll, model_pll);
        if (n == 1) partner_idle = 1'($urandom % 2);
        if (n == 6) issue_req = 1'b0;
      end
      model_pll = need;
    end else begin
      @(negedge clk);
      chk(pi ? "R4 no-switch ack" : "R3 busy ack", issue_ack, 1);
      chk(pi ? "R4 no isolation" : "R3 no isolation", bus_iso, '0);
      chk("R5 code kept", clk_src_code, old_code);
      chk("R4 no done", done, 0);
      issue_req = 1'b0;
    end
    @(negedge clk);
    chk("R8 cur after", cur_src_pll, model_pll);
    chk("R2 code settled", clk_src_code, code_of(model_pll));
    chk("R7 ack dropped", issue_ack, 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check_quiet("reset");
    chk("R1 code", clk_src_code, 8'h23);
    chk("R1 cur", cur_src_pll, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("post-reset");
    chk("R1 cur post", cur_src_pll, 0);
    // directed corners
    run_cmd(1, 1, 0);   // PCI -> PLL on write
    run_cmd(1, 1, 0);   // already PLL
    run_cmd(0, 1, 0);   // PLL -> PCI on read
    run_cmd(0, 0, 1);   // wants PLL but partner busy
    run_cmd(1, 0, 0);   // wants PLL, busy again
    run_cmd(0, 1, 1);   // 66 MHz forces PLL
    run_cmd(1, 1, 1);   // same
    run_cmd(0, 1, 0);   // back to PCI
    for (int i = 0; i < 60; i++)
      run_cmd(1'($urandom % 2), 1'(($urandom % 4) != 0), 1'($urandom % 2));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule